// File: doc/BRIEF.md
# Field-Programmable AND-OR Logic Array

This block is a sum-of-products logic array whose connection pattern sits in configuration registers, not in fixed wiring. Each of the `P` product terms forms the AND of a chosen set of input literals. An input may be taken in true form, in complemented form, or left out. Each of the `M` outputs forms the OR of any subset of the product terms. A single product term may therefore feed several outputs at once.

Each output then passes through a polarity stage. This stage either passes the sum unchanged or inverts it, so a function can be built from the product terms of its complement. Each output can also be taken from an output flip-flop instead of straight from the array. This lets the array hold the state of a sequential circuit.

Configuration is loaded through a synchronous write port. One write carries either one product-term row (the AND plane) or one output column (the OR-plane connections, the polarity bit and the flop select). The array itself is purely combinational between the inputs and the polarity stage.

Top module: `fpla_core`

## Requirements
- R1: An AND-row write places the 2-bit literal code for input `i` at row data bits `[2i+1:2i]`. Code `2'b10` requires input `i` to be 1. Code `2'b01` requires input `i` to be 0. Code `2'b00` leaves input `i` out of the term.
- R2: A literal code of `2'b11` on any input of a row holds that product term at 0 for every input pattern.
- R3: A product term whose row holds only `2'b00` codes evaluates to 1.
- R4: One product term connected to several outputs drives all of them. The OR-plane column data bit `t` connects term `t` to the output.
- R5: An output column with no connection bits set gives a sum of 0 before the polarity stage.
- R6: Column data bit `P` is the polarity. When it is 0 the output equals the sum. When it is 1 the output equals the inverted sum.
- R7: Column data bit `P+1` selects the registered path. When it is 1, the output shows the value that its polarity stage produced just before the most recent rising clock edge.
- R8: While the active-high synchronous reset `rst` is sampled high, the output flip-flops are cleared to 0. Outputs set to the combinational path keep following the array during reset.
- R9: A write (`cfg_we`, with `cfg_col` = 0 for an AND row and 1 for an output column, at index `cfg_idx`) changes outputs only after the next rising edge. It leaves every other row and column untouched.
- R10: Configured with 3 inputs and 4 terms, a2·a0', a1·a0', a2·a1 and a2'·a1', with both columns inverted, the outputs equal Σm(0,1,3,5) and Σm(3,5,7). The minterm index is `in_vec` read as a2a1a0.
- R11: Configured with terms A·C, B·C and A·B' at true polarity, with F1 = AC+BC and F2 = AC+AB', the outputs equal Σm(3,5,7) and Σm(4,5,7). Here A is `in_vec[2]` and C is `in_vec[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output flip-flops |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_col | input | 1 | 0 selects an AND-plane row, 1 selects an output column |
| cfg_idx | input | AW | Row or column index |
| cfg_data | input | DW | Row literals or {flop select, polarity, connections} |
| in_vec | input | N | Array inputs |
| out_vec | output | M | Array outputs |

## Verification
The array is swept over all eight input patterns under several configurations, each one isolating a single feature. A single true/complement row separates the two literal codes from each other. An all-absent row shows the empty-term value. A row holding a `2'b11` code shows term suppression. Connecting one term to both columns shows sharing, and switching polarity on a column flips its truth table. In registered mode, the same sweep shows a one-cycle lag against combinational mode. Two complete textbook configurations are then compared minterm by minterm with fixed truth tables, and a reference model follows every cycle, including writes that land in the middle of a sweep.

// File: rtl/fpla_pkg.sv
package fpla_pkg;

  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_NEG  = 2'b01,
    LIT_POS  = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  // contribution of one input to one product term
  function automatic logic lit_pass(input logic [1:0] code, input logic x);
    case (lit_code_e'(code))
      LIT_OFF: lit_pass = 1'b1;
      LIT_NEG: lit_pass = ~x;
      LIT_POS: lit_pass = x;
      default: lit_pass = 1'b0;
    endcase
  endfunction

  // output inverter stage modelled as an XOR
  function automatic logic pol_apply(input logic sum, input logic inv);
    pol_apply = sum ^ inv;
  endfunction

endpackage

// File: rtl/fpla_and_plane.sv
module fpla_and_plane
  import fpla_pkg::*;
#(
  parameter int N  = 3,
  parameter int P  = 4,
  parameter int AW = 2
) (
  input  logic           clk,
  input  logic           row_we,
  input  logic [AW-1:0]  row_idx,
  input  logic [2*N-1:0] row_data,
  input  logic [N-1:0]   in_vec,
  output logic [P-1:0]   term_vec,
  output logic [P-1:0]   kill_vec
);

  logic [2*N-1:0] row_q [P];

  always_ff @(posedge clk) begin
    for (int t = 0; t < P; t++) begin
      if (row_we && row_idx == AW'(t)) row_q[t] <= row_data;
    end
  end

  for (genvar t = 0; t < P; t++) begin : g_term
    always_comb begin
      logic acc;
      logic dead;
      acc  = 1'b1;
      dead = 1'b0;
      for (int i = 0; i < N; i++) begin
        acc  = acc & lit_pass(row_q[t][2*i +: 2], in_vec[i]);
        dead = dead | (row_q[t][2*i +: 2] == LIT_KILL);
      end
      term_vec[t] = acc;
      kill_vec[t] = dead;
    end
  end

endmodule

// File: rtl/fpla_or_plane.sv
module fpla_or_plane
  import fpla_pkg::*;
#(
  parameter int P  = 4,
  parameter int M  = 2,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          col_we,
  input  logic [AW-1:0] col_idx,
  input  logic [P+1:0]  col_data,
  input  logic [P-1:0]  term_vec,
  output logic [M-1:0]  sum_vec,
  output logic [M-1:0]  empty_vec,
  output logic [M-1:0]  comb_vec,
  output logic [M-1:0]  reg_sel_vec
);

  localparam int POL_BIT = P;
  localparam int REG_BIT = P + 1;

  logic [P+1:0] col_q [M];

  always_ff @(posedge clk) begin
    for (int o = 0; o < M; o++) begin
      if (col_we && col_idx == AW'(o)) col_q[o] <= col_data;
    end
  end

  for (genvar o = 0; o < M; o++) begin : g_sum
    assign sum_vec[o]     = |(term_vec & col_q[o][P-1:0]);
    assign empty_vec[o]   = ~|col_q[o][P-1:0];
    assign comb_vec[o]    = pol_apply(sum_vec[o], col_q[o][POL_BIT]);
    assign reg_sel_vec[o] = col_q[o][REG_BIT];
  end

endmodule

// File: rtl/fpla_out_stage.sv
module fpla_out_stage #(
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] comb_vec,
  input  logic [M-1:0] reg_sel_vec,
  output logic [M-1:0] q_vec,
  output logic [M-1:0] out_vec
);

  always_ff @(posedge clk) begin
    if (rst) q_vec <= '0;
    else     q_vec <= comb_vec;
  end

  for (genvar o = 0; o < M; o++) begin : g_sel
    assign out_vec[o] = reg_sel_vec[o] ? q_vec[o] : comb_vec[o];
  end

endmodule

// File: rtl/fpla_core.sv
module fpla_core #(
  parameter int N = 3,
  parameter int P = 4,
  parameter int M = 2,
  localparam int SPAN = (P > M) ? P : M,
  localparam int AW   = (SPAN > 1) ? $clog2(SPAN) : 1,
  localparam int DW   = (2*N > P+2) ? 2*N : P+2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_col,
  input  logic [AW-1:0] cfg_idx,
  input  logic [DW-1:0] cfg_data,
  input  logic [N-1:0]  in_vec,
  output logic [M-1:0]  out_vec
);

  // named internal events, observed by the bound checker
  logic          row_we;
  logic          col_we;
  logic [P-1:0]  term_vec;
  logic [P-1:0]  kill_vec;
  logic [M-1:0]  sum_vec;
  logic [M-1:0]  empty_vec;
  logic [M-1:0]  comb_vec;
  logic [M-1:0]  reg_sel_vec;
  logic [M-1:0]  q_vec;

  assign row_we = cfg_we & ~cfg_col;
  assign col_we = cfg_we & cfg_col;

  fpla_and_plane #(.N(N), .P(P), .AW(AW)) u_and (
    .clk      (clk),
    .row_we   (row_we),
    .row_idx  (cfg_idx),
    .row_data (cfg_data[2*N-1:0]),
    .in_vec   (in_vec),
    .term_vec (term_vec),
    .kill_vec (kill_vec)
  );

  fpla_or_plane #(.P(P), .M(M), .AW(AW)) u_or (
    .clk         (clk),
    .col_we      (col_we),
    .col_idx     (cfg_idx),
    .col_data    (cfg_data[P+1:0]),
    .term_vec    (term_vec),
    .sum_vec     (sum_vec),
    .empty_vec   (empty_vec),
    .comb_vec    (comb_vec),
    .reg_sel_vec (reg_sel_vec)
  );

  fpla_out_stage #(.M(M)) u_out (
    .clk         (clk),
    .rst         (rst),
    .comb_vec    (comb_vec),
    .reg_sel_vec (reg_sel_vec),
    .q_vec       (q_vec),
    .out_vec     (out_vec)
  );

endmodule

// File: rtl/fpla_core_chk.sv
module fpla_core_chk #(
  parameter int P = 4,
  parameter int M = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [P-1:0] term_vec,
  input logic [P-1:0] kill_vec,
  input logic [M-1:0] sum_vec,
  input logic [M-1:0] empty_vec,
  input logic [M-1:0] comb_vec,
  input logic [M-1:0] q_vec
);

  AST_KILLED_TERM_LOW: assert property (@(posedge clk) disable iff (rst)
    (term_vec & kill_vec) == '0); // R2

  AST_EMPTY_SUM_LOW: assert property (@(posedge clk) disable iff (rst)
    (sum_vec & empty_vec) == '0); // R5

  AST_FLOP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> q_vec == $past(comb_vec)); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q_vec == '0); // R8

endmodule

bind fpla_core fpla_core_chk #(.P(P), .M(M)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .term_vec  (term_vec),
  .kill_vec  (kill_vec),
  .sum_vec   (sum_vec),
  .empty_vec (empty_vec),
  .comb_vec  (comb_vec),
  .q_vec     (q_vec)
);

// File: tb/test_fpla_core.sv
`timescale 1ns/1ps
module test_fpla_core;

  localparam int N  = 3;
  localparam int P  = 4;
  localparam int M  = 2;
  localparam int AW = 2;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic          cfg_col = 1'b0;
  logic [AW-1:0] cfg_idx = '0;
  logic [DW-1:0] cfg_data = '0;
  logic [N-1:0]  in_vec = '0;
  logic [M-1:0]  out_vec;

  int checks = 0;
  int failures = 0;
  bit armed = 1'b0;
  string tag = "R8";

  logic [DW-1:0] m_row [P];
  logic [DW-1:0] m_col [M];
  logic [M-1:0]  m_q = '0;

  always #2 clk = ~clk;

  fpla_core #(.N(N), .P(P), .M(M)) i_fpla_core (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_col(cfg_col),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .in_vec(in_vec), .out_vec(out_vec)
  );

  // ---------------- reference model ----------------
  function automatic bit m_term(int t);
    for (int i = 0; i < N; i++) begin
      int code = int'((m_row[t] >> (2*i)) & 3);
      if (code == 3) return 1'b0;
      if (code == 2 && !in_vec[i]) return 1'b0;
      if (code == 1 && in_vec[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit m_comb(int o);
    bit s = 1'b0;
    for (int t = 0; t < P; t++)
      if (m_col[o][t] && m_term(t)) s = 1'b1;
    return s ^ m_col[o][P];
  endfunction

  function automatic logic [M-1:0] m_out();
    logic [M-1:0] r;
    for (int o = 0; o < M; o++) r[o] = m_col[o][P+1] ? m_q[o] : m_comb(o);
    return r;
  endfunction

  always @(posedge clk) begin
    for (int o = 0; o < M; o++) m_q[o] = rst ? 1'b0 : m_comb(o);
    if (cfg_we) begin
      if (cfg_col) m_col[cfg_idx] = cfg_data;
      else         m_row[cfg_idx] = cfg_data;
    end
  end

  // ---------------- checking ----------------
  task automatic check(string req, logic [M-1:0] got, logic [M-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s t=%0t in=%b actual=%b expected=%b", req, $time, in_vec, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (armed) check(tag, out_vec, m_out());
  end

  task automatic wr(bit col, int idx, logic [DW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_col = col; cfg_idx = AW'(idx); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sweep();
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      in_vec = N'(v);
    end
  endtask

  task automatic truth(string req, logic [7:0] f0, logic [7:0] f1);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      in_vec = N'(v);
      #1;
      check(req, out_vec, {f1[v], f0[v]});
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // reset held: load config, both outputs registered
    for (int t = 0; t < P; t++) wr(1'b0, t, 6'b00_00_00);
    wr(1'b1, 0, 6'b10_0000);
    wr(1'b1, 1, 6'b10_0000);
    armed = 1'b1;
    @(negedge clk); #1;
    check("R8", out_vec, 2'b00);                 // R8 flops cleared under reset
    tag = "R8";
    wr(1'b1, 1, 6'b01_0000);                     // comb, inverted, empty
    @(negedge clk); #1;
    check("R8", out_vec, 2'b10);                 // R8/R5 comb output live in reset
    @(negedge clk); rst = 1'b0;

    tag = "R3";
    wr(1'b1, 0, 6'b00_0001);                     // out0 = term0, all absent
    truth("R3", 8'hFF, 8'hFF);

    tag = "R1";
    wr(1'b0, 0, 6'b00_01_10);                    // in0 true, in1 complement
    truth("R1", 8'b0010_0010, 8'hFF);            // v=1,5

    tag = "R2";
    wr(1'b0, 1, 6'b11_00_00);
    wr(1'b1, 1, 6'b00_0010);                     // out1 = killed term1
    truth("R2", 8'b0010_0010, 8'h00);

    tag = "R4";
    wr(1'b1, 1, 6'b00_0011);                     // term0 shared
    truth("R4", 8'b0010_0010, 8'b0010_0010);

    tag = "R6";
    wr(1'b1, 1, 6'b01_0011);
    truth("R6", 8'b0010_0010, 8'b1101_1101);

    tag = "R5";
    wr(1'b1, 1, 6'b00_0000);
    truth("R5", 8'b0010_0010, 8'h00);

    tag = "R7";
    wr(1'b1, 0, 6'b10_0001);                     // out0 registered
    sweep();
    sweep();

    tag = "R9";
    wr(1'b0, 0, 6'b00_00_00);                    // mid-stream row change
    wr(1'b1, 0, 6'b00_0001);
    @(negedge clk); in_vec = 3'b000; #1;
    check("R9", out_vec, 2'b01);
    sweep();

    tag = "R10";
    wr(1'b0, 0, 6'b10_00_01);
    wr(1'b0, 1, 6'b00_10_01);
    wr(1'b0, 2, 6'b10_10_00);
    wr(1'b0, 3, 6'b01_01_00);
    wr(1'b1, 0, 6'b01_0111);
    wr(1'b1, 1, 6'b01_1011);
    truth("R10", 8'h2B, 8'hA8);

    tag = "R11";
    wr(1'b0, 0, 6'b10_00_10);
    wr(1'b0, 1, 6'b00_10_10);
    wr(1'b0, 2, 6'b10_01_00);
    wr(1'b0, 3, 6'b11_11_11);
    wr(1'b1, 0, 6'b00_0011);
    wr(1'b1, 1, 6'b00_0101);
    truth("R11", 8'hA8, 8'hB0);

    tag = "R8";
    wr(1'b1, 1, 6'b10_0101);                     // out1 registered
    @(negedge clk); in_vec = 3'b111; rst = 1'b1;
    @(negedge clk); #1;
    check("R8", out_vec, 2'b01);                 // flop cleared, comb out0 live
    @(negedge clk); rst = 1'b0;
    sweep();

    @(negedge clk);
    finish_run();
  end

endmodule